// File: doc/BRIEF.md
# Fine-Grain Thread Select Unit

This block chooses, on every clock cycle, which hardware thread context issues into a single-issue, in-order pipeline. Each thread owns its own program counter and instruction buffer. The one-hot and encoded select outputs steer the muxes in front of those per-thread resources. A valid flag tells the pipeline whether anything issues in this cycle.

Selection interleaves the threads in round-robin order. The selected thread may differ on each cycle, and a switch costs no cycle. A thread is passed over while it cannot issue. The stall causes arrive as per-thread masks: an outstanding cache miss, a resource conflict, and a long-latency instruction type at the head of the thread. A pending trap or interrupt overrides all three, so the thread gets to issue and take its handler. A thread also needs its enable bit before it can be chosen.

The rotation pointer is the block's only state. A two-state mode word drives it. In ISSUE the pick logic has found an eligible thread, and on the next edge the pointer moves to the thread after the granted one (transition ISSUE->advance). In IDLE no thread is eligible, and the pointer holds its value (transition IDLE->hold). Reset places the pointer at thread 0.

Top module: `thread_select`

## Requirements
- R1: Thread i is eligible when `thr_enable[i]` is 1 and none of `miss_pend[i]`, `res_conflict[i]` or `long_op[i]` is set. Only an eligible thread is ever selected.
- R2: A thread with `trap_pend[i]` set is eligible whenever it is enabled, whatever its miss, conflict and long-latency bits are.
- R3: A thread with `thr_enable[i]` at 0 is never selected, even when its trap bit is set.
- R4: In a given cycle the selected thread is the first eligible thread found when counting upward from the pointer, with index N-1 wrapping to index 0.
- R5: After a cycle with `sel_valid` at 1 and thread g selected, the pointer holds (g+1) mod N. A thread that stays eligible is therefore selected within N cycles.
- R6: When no thread is eligible, `sel_valid`, `sel_onehot` and `sel_id` are all 0, and the pointer keeps its value through that cycle.
- R7: `sel_onehot` has exactly bit `sel_id` set when `sel_valid` is 1, and is all zero otherwise. Bit i stands for thread i.
- R8: Reset (active-low `rst_n`) sets the pointer to thread 0. The outputs are combinational, so while reset is held they still follow the eligibility inputs.
- R9: With every thread eligible, the selection changes on every cycle in the order 0, 1, 2, 3, 0, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_enable | input | N | Thread context enabled, bit per thread |
| miss_pend | input | N | Cache miss outstanding, bit per thread |
| trap_pend | input | N | Trap or interrupt pending, bit per thread |
| res_conflict | input | N | Shared resource conflict, bit per thread |
| long_op | input | N | Long-latency instruction type at head, bit per thread |
| sel_onehot | output | N | One-hot thread select to the PC and instruction-buffer muxes |
| sel_id | output | $clog2(N) | Encoded thread select |
| sel_valid | output | 1 | An eligible thread was selected this cycle |

## Verification
The bench builds the block with the default N = 4. With four threads the pointer wrap from thread 3 to thread 0 is reached, and so is every skip distance from zero up to three threads. Directed sequences cover the single-stall patterns, the trap override and a disabled thread that has a pending trap. They also cover the all-stalled hold and the resume that follows it. A long run of pseudo-random masks then combines all of these against the bench's own rotation model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic {
        SEL_IDLE  = 1'b0,
        SEL_ISSUE = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/tsel_elig.sv
module tsel_elig #(
    parameter int N = 4
) (
    input  logic [N-1:0] thr_enable,
    input  logic [N-1:0] miss_pend,
    input  logic [N-1:0] trap_pend,
    input  logic [N-1:0] res_conflict,
    input  logic [N-1:0] long_op,
    output logic [N-1:0] eligible
);

    for (genvar t = 0; t < N; t++) begin : g_thr
        logic blocked;
        assign blocked     = miss_pend[t] | res_conflict[t] | long_op[t];
        assign eligible[t] = thr_enable[t] & (trap_pend[t] | ~blocked);
    end

endmodule

// File: rtl/tsel_pick.sv
module tsel_pick
    import tsel_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   eligible,
    input  logic [IDW-1:0] rr_ptr,
    output logic [IDW-1:0] grant_id,
    output logic [N-1:0]   grant_oh,
    output sel_mode_e      mode
);

    logic found;

    always_comb begin
        found    = 1'b0;
        grant_id = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(rr_ptr) + k) % N;
            if (!found && eligible[idx]) begin
                found    = 1'b1;
                grant_id = IDW'(idx);
            end
        end
    end

    always_comb begin
        unique case (found)
            1'b1: begin
                mode     = SEL_ISSUE;
                grant_oh = N'(1) << grant_id;
            end
            default: begin
                mode     = SEL_IDLE;
                grant_oh = '0;
            end
        endcase
    end

endmodule

// File: rtl/tsel_ptr.sv
module tsel_ptr
    import tsel_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  sel_mode_e      mode,
    input  logic [IDW-1:0] grant_id,
    output logic [IDW-1:0] rr_ptr
);

    localparam logic [IDW-1:0] LAST = IDW'(N - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else begin
            unique case (mode)
                SEL_ISSUE: rr_ptr <= (grant_id == LAST) ? '0 : grant_id + IDW'(1);
                SEL_IDLE:  rr_ptr <= rr_ptr;
                default:   rr_ptr <= rr_ptr;
            endcase
        end
    end

endmodule

// File: rtl/thread_select.sv
module thread_select
    import tsel_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   thr_enable,
    input  logic [N-1:0]   miss_pend,
    input  logic [N-1:0]   trap_pend,
    input  logic [N-1:0]   res_conflict,
    input  logic [N-1:0]   long_op,
    output logic [N-1:0]   sel_onehot,
    output logic [IDW-1:0] sel_id,
    output logic           sel_valid
);

    logic [N-1:0]   eligible;
    logic [IDW-1:0] rr_ptr;
    logic [IDW-1:0] grant_id;
    logic [N-1:0]   grant_oh;
    sel_mode_e      mode;

    tsel_elig #(.N(N)) u_elig (
        .thr_enable   (thr_enable),
        .miss_pend    (miss_pend),
        .trap_pend    (trap_pend),
        .res_conflict (res_conflict),
        .long_op      (long_op),
        .eligible     (eligible)
    );

    tsel_pick #(.N(N), .IDW(IDW)) u_pick (
        .eligible (eligible),
        .rr_ptr   (rr_ptr),
        .grant_id (grant_id),
        .grant_oh (grant_oh),
        .mode     (mode)
    );

    tsel_ptr #(.N(N), .IDW(IDW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .grant_id (grant_id),
        .rr_ptr   (rr_ptr)
    );

    always_comb begin
        unique case (mode)
            SEL_ISSUE: begin
                sel_valid  = 1'b1;
                sel_id     = grant_id;
                sel_onehot = grant_oh;
            end
            default: begin
                sel_valid  = 1'b0;
                sel_id     = '0;
                sel_onehot = '0;
            end
        endcase
    end

endmodule

// File: rtl/tsel_chk.sv
module tsel_chk #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   thr_enable,
    input logic [N-1:0]   miss_pend,
    input logic [N-1:0]   trap_pend,
    input logic [N-1:0]   res_conflict,
    input logic [N-1:0]   long_op,
    input logic [N-1:0]   sel_onehot,
    input logic [IDW-1:0] sel_id,
    input logic           sel_valid,
    input logic [IDW-1:0] rr_ptr
);

    localparam logic [IDW-1:0] LAST = IDW'(N - 1);

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot) && (sel_valid == (|sel_onehot)));

    p_bitmatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> sel_onehot[sel_id]);

    p_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> thr_enable[sel_id]);

    p_unblocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (trap_pend[sel_id] ||
                       !(miss_pend[sel_id] || res_conflict[sel_id] || long_op[sel_id])));

    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> rr_ptr == (($past(sel_id) == LAST) ? '0 : $past(sel_id) + IDW'(1)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> $stable(rr_ptr));

    p_ptrfirst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_id != rr_ptr) |->
            !(thr_enable[rr_ptr] && (trap_pend[rr_ptr] ||
              !(miss_pend[rr_ptr] || res_conflict[rr_ptr] || long_op[rr_ptr]))));

endmodule

bind thread_select tsel_chk #(.N(N), .IDW(IDW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_enable   (thr_enable),
    .miss_pend    (miss_pend),
    .trap_pend    (trap_pend),
    .res_conflict (res_conflict),
    .long_op      (long_op),
    .sel_onehot   (sel_onehot),
    .sel_id       (sel_id),
    .sel_valid    (sel_valid),
    .rr_ptr       (rr_ptr)
);

// File: tb/test_thread_select.sv
module test_thread_select;

    localparam int NT  = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NT-1:0]  en = '0, miss = '0, trap = '0, conf = '0, lng = '0;
    logic [NT-1:0]  sel_onehot;
    logic [IDW-1:0] sel_id;
    logic           sel_valid;

    int checks = 0;
    int fails  = 0;
    bit stim_done = 1'b0;
    int model_ptr = 0;

    typedef struct {
        logic           v;
        logic [IDW-1:0] id;
        logic [NT-1:0]  oh;
        string          tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    thread_select #(.N(NT)) i_thread_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_enable   (en),
        .miss_pend    (miss),
        .trap_pend    (trap),
        .res_conflict (conf),
        .long_op      (lng),
        .sel_onehot   (sel_onehot),
        .sel_id       (sel_id),
        .sel_valid    (sel_valid)
    );

    function automatic bit elig(int t);
        return en[t] && (trap[t] || !(miss[t] || conf[t] || lng[t]));
    endfunction

    task automatic check(string tag, logic v, logic [IDW-1:0] id, logic [NT-1:0] oh);
        checks++;
        if (sel_valid !== v || sel_id !== id || sel_onehot !== oh) begin
            fails++;
            $display("FAIL %s: got v=%0b id=%0d oh=%b, expected v=%0b id=%0d oh=%b",
                     tag, sel_valid, sel_id, sel_onehot, v, id, oh);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected select
    task automatic drive(string tag, logic [NT-1:0] e, logic [NT-1:0] m,
                         logic [NT-1:0] tp, logic [NT-1:0] c, logic [NT-1:0] l);
        exp_t x;
        @(negedge clk);
        en = e; miss = m; trap = tp; conf = c; lng = l;
        x.v = 1'b0; x.id = '0; x.oh = '0; x.tag = tag;
        for (int k = 0; k < NT; k++) begin
            int idx;
            idx = (model_ptr + k) % NT;
            if (!x.v && elig(idx)) begin
                x.v  = 1'b1;
                x.id = IDW'(idx);
                x.oh = NT'(1) << idx;
            end
        end
        if (x.v) model_ptr = (int'(x.id) + 1) % NT;
        sb.push_back(x);
    endtask

    // Monitor: compares mid-cycle, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check(x.tag, x.v, x.id, x.oh);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!stim_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: while reset is held, nothing enabled -> idle outputs
        repeat (2) @(negedge clk);
        #5 check("R8 reset idle", 1'b0, '0, '0);
        // R8: pointer at 0 in reset, all eligible -> thread 0
        en = '1;
        #2 check("R8 reset ptr0", 1'b1, 2'd0, 4'b0001);
        @(negedge clk);
        #5 check("R8 reset held ptr0", 1'b1, 2'd0, 4'b0001);
        en = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R9: every thread eligible -> 0,1,2,3,0
        for (int i = 0; i < 5; i++) drive("R9 rotate", 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
        // pointer now 1. R1: miss on thread 1 is skipped
        drive("R1 skip miss", 4'hF, 4'b0010, 4'h0, 4'h0, 4'h0);
        // R1: conflict on 3, long op on 0 -> after 2 comes 1
        drive("R1 skip conf", 4'hF, 4'h0, 4'h0, 4'b1000, 4'b0001);
        // R2: trap overrides miss on thread 2
        drive("R2 trap override", 4'hF, 4'b0100, 4'b0100, 4'b0100, 4'b0100);
        drive("R2 trap only", 4'hF, 4'b1011, 4'b0100, 4'h0, 4'h0);
        // R3: disabled thread with trap is never picked
        drive("R3 disabled trap", 4'b0001, 4'h0, 4'b1110, 4'h0, 4'h0);
        drive("R3 none enabled", 4'h0, 4'h0, 4'hF, 4'h0, 4'h0);
        // R6: all stalled -> idle, pointer held
        drive("R6 all stalled", 4'hF, 4'b0011, 4'h0, 4'b0100, 4'b1000);
        drive("R6 still stalled", 4'hF, 4'hF, 4'h0, 4'h0, 4'h0);
        drive("R6 resume", 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
        // R4: single eligible thread far from pointer, wrap
        drive("R4 far", 4'hF, 4'b1110, 4'h0, 4'h0, 4'h0);
        drive("R4 wrap", 4'b1000, 4'h0, 4'h0, 4'h0, 4'h0);
        drive("R5 after wrap", 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
        // R4 R5 R7: pseudo-random mix
        for (int i = 0; i < 400; i++) begin
            logic [NT-1:0] e;
            e = NT'($urandom) | NT'($urandom);
            drive("R4 random", e, NT'($urandom) & NT'($urandom), NT'($urandom) & NT'($urandom),
                  NT'($urandom) & NT'($urandom), NT'($urandom) & NT'($urandom));
        end
        repeat (3) @(negedge clk);
        stim_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule